// File: doc/BRIEF.md
# Predicated Vector Magnitude Comparator

This unit compares the magnitudes of IEEE floating-point lanes taken from two vector operands. It writes one result per lane into a destination predicate that has one bit per byte of the vector. The lane width is chosen by a two-bit size code: half, single or double precision. A single control bit picks the operation, either strictly greater or greater-or-equal. Less-than forms are obtained by swapping the operands at the caller.

A governing predicate, also one bit per byte, enables each lane. A lane that is enabled gets its compare result in the lowest bit of its predicate group, and the other bits of that group are zero. A lane that is not enabled gets an all-zero group. The reserved size code raises an illegal flag and yields an all-zero predicate. Both outputs are registered once, so results appear one clock after the inputs are sampled.

Top module: `vmag_cmp_unit`

## Requirements
- R1: Size code 01 selects 16-bit lanes, 10 selects 32-bit lanes and 11 selects 64-bit lanes. Lane k occupies operand bits [k*W +: W] and predicate bits [k*W/8 +: W/8], where W is the lane width.
- R2: Size code 00 drives illegal_o to 1 and dst_pred_o to all zeros. Any other code drives illegal_o to 0.
- R3: For an enabled lane, bit k*W/8 of dst_pred_o holds the compare result, and every higher bit of that lane's group is 0.
- R4: A lane is enabled only by gov_pred_i bit k*W/8. When that bit is clear, the whole group is 0, whatever the other governing bits of the group hold.
- R5: op_gt_i=1 yields |a|>|b|. op_gt_i=0 yields |a|>=|b|.
- R6: The sign bit (the top bit of each lane) has no effect on the result.
- R7: If either lane operand is a NaN (exponent all ones with a nonzero fraction; exponent widths 5/8/11), the lane result is 0 for both operations. Infinities compare as the largest finite-ordered values.
- R8: +0 and -0 are equal: greater-or-equal gives 1 and greater gives 0.
- R9: Outputs reflect the inputs sampled at the previous rising clock_i edge. While rst_ni is low, dst_pred_o and illegal_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vec_a_i | input | VLEN | First operand vector |
| vec_b_i | input | VLEN | Second operand vector |
| gov_pred_i | input | VLEN/8 | Governing predicate, one bit per byte |
| size_i | input | 2 | Lane size code |
| op_gt_i | input | 1 | 1: greater, 0: greater-or-equal |
| dst_pred_o | output | VLEN/8 | Destination predicate, registered |
| illegal_o | output | 1 | Reserved size code seen, registered |

## Verification
Each lane owns its own compare logic, so a fault in one lane or in the predicate expansion shows up as a wrong bit in that lane's group on the next cycle. It can appear as a set bit above the group base, as a bit set under a clear governing bit, or as a flipped result. The bench compares the full predicate against its own model after every applied vector, one cycle after the drive. A fault in the size multiplexer corrupts every lane at once, and the illegal flag exposes a wrong decode of code 00 in the same cycle.

// File: rtl/vmag_pkg.sv
package vmag_pkg;
  typedef enum logic [1:0] {
    SZ_RSVD = 2'b00,
    SZ_HALF = 2'b01,
    SZ_SGL  = 2'b10,
    SZ_DBL  = 2'b11
  } elem_size_e;

  function automatic int exp_width(input int w);
    return (w == 16) ? 5 : (w == 32) ? 8 : 11;
  endfunction
endpackage

// File: rtl/vmag_lane.sv
module vmag_lane #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         gt_i,
  output logic         res_o
);
  localparam int EW = vmag_pkg::exp_width(W);
  localparam int FW = W - 1 - EW;

  logic [W-2:0] mag_a, mag_b;
  logic         nan_a, nan_b;

  assign mag_a = a_i[W-2:0];
  assign mag_b = b_i[W-2:0];
  assign nan_a = (&mag_a[W-2:FW]) && (|mag_a[FW-1:0]);
  assign nan_b = (&mag_b[W-2:FW]) && (|mag_b[FW-1:0]);

  always_comb begin
    if (nan_a || nan_b) res_o = 1'b0;
    else if (gt_i)      res_o = mag_a > mag_b;
    else                res_o = mag_a >= mag_b;
  end
endmodule

// File: rtl/vmag_lane_array.sv
module vmag_lane_array #(
  parameter int VLEN = 128,
  parameter int W    = 16
) (
  input  logic [VLEN-1:0]   vec_a_i,
  input  logic [VLEN-1:0]   vec_b_i,
  input  logic [VLEN/8-1:0] gov_i,
  input  logic              gt_i,
  output logic [VLEN/8-1:0] pred_o
);
  localparam int NL  = VLEN / W;
  localparam int GRP = W / 8;

  for (genvar k = 0; k < NL; k++) begin : g_lane
    logic res;
    vmag_lane #(.W(W)) u_lane (
      .a_i  (vec_a_i[k*W +: W]),
      .b_i  (vec_b_i[k*W +: W]),
      .gt_i (gt_i),
      .res_o(res)
    );
    assign pred_o[k*GRP] = res & gov_i[k*GRP];
    if (GRP > 1) begin : g_pad
      assign pred_o[k*GRP+1 +: GRP-1] = '0;
    end
  end
endmodule

// File: rtl/vmag_cmp_unit.sv
module vmag_cmp_unit #(
  parameter int VLEN = 128,
  localparam int PB  = VLEN / 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [VLEN-1:0] vec_a_i,
  input  logic [VLEN-1:0] vec_b_i,
  input  logic [PB-1:0]   gov_pred_i,
  input  logic [1:0]      size_i,
  input  logic            op_gt_i,
  output logic [PB-1:0]   dst_pred_o,
  output logic            illegal_o
);
  import vmag_pkg::*;

  logic [PB-1:0] cand [1:3];
  logic [PB-1:0] pred_d;
  logic          ill_d;

  for (genvar s = 1; s < 4; s++) begin : g_size
    vmag_lane_array #(.VLEN(VLEN), .W(8 << s)) u_arr (
      .vec_a_i(vec_a_i),
      .vec_b_i(vec_b_i),
      .gov_i  (gov_pred_i),
      .gt_i   (op_gt_i),
      .pred_o (cand[s])
    );
  end

  always_comb begin
    ill_d  = 1'b0;
    pred_d = '0;
    unique case (elem_size_e'(size_i))
      SZ_HALF: pred_d = cand[1];
      SZ_SGL:  pred_d = cand[2];
      SZ_DBL:  pred_d = cand[3];
      default: ill_d  = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dst_pred_o <= '0;
      illegal_o  <= 1'b0;
    end else begin
      dst_pred_o <= pred_d;
      illegal_o  <= ill_d;
    end
  end
endmodule

// File: rtl/vmag_cmp_unit_chk.sv
module vmag_cmp_unit_chk #(
  parameter int VLEN = 128,
  localparam int PB  = VLEN / 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [PB-1:0] gov_pred_i,
  input logic [1:0]    size_i,
  input logic [PB-1:0] dst_pred_o,
  input logic          illegal_o
);
  function automatic logic [PB-1:0] base_mask(input logic [1:0] sz);
    logic [PB-1:0] m;
    m = '0;
    for (int i = 0; i < PB; i++)
      if (sz != 2'b00 && (i % (1 << sz)) == 0) m[i] = 1'b1;
    return m;
  endfunction

  // R2
  a_r2_illegal_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (dst_pred_o == '0));
  a_r2_flag_follows_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (illegal_o == ($past(size_i) == 2'b00)));
  // R4
  a_r4_inactive_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((dst_pred_o & ~$past(gov_pred_i)) == '0));
  // R3
  a_r3_group_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((dst_pred_o & ~base_mask($past(size_i))) == '0));
  // R9
  always @(posedge clk_i)
    if (!rst_ni) a_r9_reset_clear: assert (dst_pred_o == '0 && !illegal_o);
endmodule

bind vmag_cmp_unit vmag_cmp_unit_chk #(.VLEN(VLEN)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .gov_pred_i(gov_pred_i),
  .size_i    (size_i),
  .dst_pred_o(dst_pred_o),
  .illegal_o (illegal_o)
);

// File: tb/vmag_cmp_unit_bench.sv
module vmag_cmp_unit_bench;
  localparam int VL = 128;
  localparam int PB = VL / 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [VL-1:0] vec_a_i = '0, vec_b_i = '0;
  logic [PB-1:0] gov_pred_i = '0;
  logic [1:0]    size_i = 2'b01;
  logic          op_gt_i = 1'b0;
  logic [PB-1:0] dst_pred_o;
  logic          illegal_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  vmag_cmp_unit #(.VLEN(VL)) u_vmag_cmp_unit (.*);

  function automatic logic [PB-1:0] ref_pred(input logic [VL-1:0] a, input logic [VL-1:0] b,
      input logic [PB-1:0] g, input logic [1:0] sz, input logic gt);
    logic [PB-1:0] r;
    int w, grp, ebits, fbits;
    r = '0;
    if (sz == 2'b00) return r;
    w = 8 << sz; grp = w / 8;
    ebits = (sz == 2'b01) ? 5 : (sz == 2'b10) ? 8 : 11;
    fbits = w - 1 - ebits;
    for (int k = 0; k < VL / w; k++) begin
      logic [63:0] ea, eb, emask, fmask;
      logic na, nb, res;
      ea = '0; eb = '0;
      for (int i = 0; i < w - 1; i++) begin
        ea[i] = a[k*w+i];
        eb[i] = b[k*w+i];
      end
      emask = (64'd1 << ebits) - 64'd1;
      fmask = (64'd1 << fbits) - 64'd1;
      na = (((ea >> fbits) & emask) == emask) && ((ea & fmask) != 0);
      nb = (((eb >> fbits) & emask) == emask) && ((eb & fmask) != 0);
      res = (na || nb) ? 1'b0 : (gt ? (ea > eb) : (ea >= eb));
      if (g[k*grp]) r[k*grp] = res;
    end
    return r;
  endfunction

  function automatic logic [VL-1:0] fill(input logic [63:0] v, input logic [1:0] sz);
    logic [VL-1:0] o;
    int w;
    w = 8 << sz;
    o = '0;
    for (int k = 0; k < VL / w; k++)
      for (int i = 0; i < w; i++) o[k*w+i] = v[i];
    return o;
  endfunction

  task automatic check(input string req, input logic [PB-1:0] exp_p, input logic exp_i);
    n_chk++;
    if (dst_pred_o !== exp_p || illegal_o !== exp_i) begin
      n_fail++;
      $display("FAIL %s: pred=%h ill=%b expected pred=%h ill=%b", req, dst_pred_o, illegal_o,
               exp_p, exp_i);
    end
  endtask

  task automatic apply(input string req, input logic [VL-1:0] a, input logic [VL-1:0] b,
      input logic [PB-1:0] g, input logic [1:0] sz, input logic gt);
    @(negedge clk_i);
    vec_a_i = a; vec_b_i = b; gov_pred_i = g; size_i = sz; op_gt_i = gt;
    @(posedge clk_i);
    @(negedge clk_i);
    check(req, ref_pred(a, b, g, sz, gt), sz == 2'b00);
  endtask

  task automatic t_reset;
    #1 check("R9 reset", '0, 1'b0);
    @(negedge clk_i); rst_ni = 1'b1;
  endtask

  task automatic t_sizes;
    // R1 R5: 2.0 vs 1.0 in each width, then swapped (less-than form)
    apply("R1 R5 half gt", fill(64'h4000, 2'b01), fill(64'h3C00, 2'b01), '1, 2'b01, 1'b1);
    check("R1 half pattern", 16'h5555, 1'b0);
    apply("R5 half swapped", fill(64'h3C00, 2'b01), fill(64'h4000, 2'b01), '1, 2'b01, 1'b1);
    check("R5 swapped zero", '0, 1'b0);
    apply("R1 single", fill(64'h4000_0000, 2'b10), fill(64'h3F80_0000, 2'b10), '1, 2'b10, 1'b0);
    check("R1 single pattern", 16'h1111, 1'b0);
    apply("R1 double", fill(64'h4000_0000_0000_0000, 2'b11), fill(64'h3FF0_0000_0000_0000, 2'b11),
          '1, 2'b11, 1'b1);
    check("R1 double pattern", 16'h0101, 1'b0);
    apply("R5 equal ge", fill(64'h3C00, 2'b01), fill(64'h3C00, 2'b01), '1, 2'b01, 1'b0);
    apply("R5 equal gt", fill(64'h3C00, 2'b01), fill(64'h3C00, 2'b01), '1, 2'b01, 1'b1);
    check("R5 equal gt zero", '0, 1'b0);
  endtask

  task automatic t_sign;
    apply("R6 neg a", fill(64'hC000, 2'b01), fill(64'h3C00, 2'b01), '1, 2'b01, 1'b1);
    check("R6 neg a value", 16'h5555, 1'b0);
    apply("R6 neg b single", fill(64'h3F80_0000, 2'b10), fill(64'hC000_0000, 2'b10), '1, 2'b10, 1'b0);
    check("R6 neg b value", '0, 1'b0);
  endtask

  task automatic t_nan;
    apply("R7 nan a ge", fill(64'h7E00, 2'b01), fill(64'h3C00, 2'b01), '1, 2'b01, 1'b0);
    check("R7 nan a zero", '0, 1'b0);
    apply("R7 nan b double", fill(64'h0, 2'b11), fill(64'hFFF8_0000_0000_0001, 2'b11), '1, 2'b11, 1'b0);
    check("R7 nan b zero", '0, 1'b0);
    apply("R7 inf gt", fill(64'h7F80_0000, 2'b10), fill(64'h7F7F_FFFF, 2'b10), '1, 2'b10, 1'b1);
    check("R7 inf value", 16'h1111, 1'b0);
    apply("R7 inf eq ge", fill(64'hFC00, 2'b01), fill(64'h7C00, 2'b01), '1, 2'b01, 1'b0);
  endtask

  task automatic t_zero;
    apply("R8 zero ge", fill(64'h8000, 2'b01), fill(64'h0000, 2'b01), '1, 2'b01, 1'b0);
    check("R8 zero ge value", 16'h5555, 1'b0);
    apply("R8 zero gt", fill(64'h0, 2'b11), fill(64'h8000_0000_0000_0000, 2'b11), '1, 2'b11, 1'b1);
    check("R8 zero gt value", '0, 1'b0);
  endtask

  task automatic t_inactive;
    // R4: only non-base bits set in every group, so all lanes are disabled
    apply("R4 upper bits only", fill(64'h4000_0000, 2'b10), '0, 16'hEEEE, 2'b10, 1'b1);
    check("R4 none active", '0, 1'b0);
    apply("R4 mixed half", fill(64'h4000, 2'b01), fill(64'h3C00, 2'b01), 16'h0F31, 2'b01, 1'b1);
    check("R3 R4 mixed value", 16'h0511, 1'b0);
  endtask

  task automatic t_illegal;
    apply("R2 reserved", fill(64'h4000, 2'b01), '0, '1, 2'b00, 1'b1);
    check("R2 reserved value", '0, 1'b1);
    apply("R2 back to legal", fill(64'h4000, 2'b01), '0, '1, 2'b01, 1'b1);
  endtask

  task automatic t_mixed;
    for (int n = 0; n < 300; n++) begin
      logic [VL-1:0] a, b;
      a = {$urandom, $urandom, $urandom, $urandom};
      b = {$urandom, $urandom, $urandom, $urandom};
      if (n % 3 == 0) b = a ^ {4{32'h8000_8000}};
      apply("R1 R3 mixed", a, b, 16'($urandom), 2'($urandom), 1'($urandom));
    end
  endtask

  initial begin
    t_reset();
    t_sizes();
    t_sign();
    t_nan();
    t_zero();
    t_inactive();
    t_illegal();
    t_mixed();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule